// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a vector of already-synchronized general-purpose input lines and asserts a single interrupt request whenever a chosen event occurs on any line whose mask bit is set. Event detection runs on every line whatever that line is used for elsewhere in the chip, so it works for inputs, for lines the chip drives as outputs and for lines handed to a peripheral.

By default a line reports any change of level. A per-line extended-mode bit narrows this to one of four events: a rising edge, a falling edge, a high level or a low level. Two further per-line bits choose between edge and level detection and set the polarity. Every setting sits behind its own write-one-to-set and write-one-to-clear addresses, so software can change single lines without a read-modify-write, and each setting can be read back.

Each detected event sets a per-line sticky status bit. Reading the status register returns the latched bits and clears them in the same access. Edges are found by comparing the present input with the sample taken one clock earlier.

Top module: `pin_event_irq`

## Requirements
- R1: After reset the mask, extended-mode, kind and polarity readbacks are all 0, status is 0 and `irq_o` is low. A line that already differs from 0 when reset is released produces no event.
- R2: A write to address 0x0 sets every mask bit where the write data is 1. A write to 0x1 clears every mask bit where the data is 1. Bits written as 0 keep their value. Address 0x2 reads the mask.
- R3: A write to 0x3 sets extended-mode bits and a write to 0x4 clears them, both write-one semantics. Address 0x5 reads them back.
- R4: A write to 0x7 selects level detection (kind bit = 1) and a write to 0x6 selects edge detection (kind bit = 0), for the lines written as 1. Address 0x8 reads the kind bits.
- R5: A write to 0xA selects rising/high polarity (bit = 1) and a write to 0x9 selects falling/low polarity (bit = 0), for the lines written as 1. Address 0xB reads the polarity bits.
- R6: With the extended-mode bit at 0, both a rising and a falling change on a line set its status bit at the next clock edge.
- R7: With the extended-mode bit at 1 and kind = edge, only a rising change sets status when polarity = 1, and only a falling change sets status when polarity = 0.
- R8: With the extended-mode bit at 1 and kind = level, status is set at every clock edge while the line is at the selected level (1 for polarity 1, 0 for polarity 0). It sets again after a clearing read for as long as the level persists, and stops once the level goes away.
- R9: A read of 0xC returns the latched status and clears it at that clock edge. An event that occurs in the same cycle as the read is kept, so it is not lost.
- R10: `irq_o` is high exactly when some line has both its status bit and its mask bit set. Status latches whether or not the line is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_LINES | Synchronized line levels |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | NUM_LINES | Write data, one bit per line |
| bus_rdata_o | output | NUM_LINES | Read data for the addressed register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench checks that an unmasked line still latches status, so a design that gated status with the mask would keep that line's bit at zero. It raises both edges of a line placed in falling-edge mode, which catches swapped polarity. It holds a low level across several clearing reads, so a level detector that fired only once would read zero on the second read. It lands a pin change in the same cycle as a status read to catch a clear that wins over a new event. It also releases reset with lines already high, which catches a spurious edge against a zeroed previous sample.

// File: rtl/piq_pkg.sv
package piq_pkg;

  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_SET = 4'h0,
    A_MASK_CLR = 4'h1,
    A_MASK     = 4'h2,
    A_XM_SET   = 4'h3,
    A_XM_CLR   = 4'h4,
    A_XM       = 4'h5,
    A_EDGE     = 4'h6,
    A_LEVEL    = 4'h7,
    A_KIND     = 4'h8,
    A_POL_LO   = 4'h9,
    A_POL_HI   = 4'hA,
    A_POL      = 4'hB,
    A_STAT     = 4'hC
  } addr_e;

endpackage

// File: rtl/piq_setclr_reg.sv
module piq_setclr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_d, q_q;
  logic         upd;

  always_comb begin
    upd = set_en_i | clr_en_i;
    q_d = q_q;
    if (set_en_i) q_d = q_d | data_i;
    if (clr_en_i) q_d = q_d & ~data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_q <= '0;
    else if (upd) q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/piq_detect.sv
module piq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] xmode_i,
  input  logic [W-1:0] kind_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] evt_o
);

  logic [W-1:0] prev_q;
  logic         primed_q;

  // previous sample follows the input every cycle; the primed flag keeps the
  // first cycle after reset from comparing against a reset value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pins_i;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise, fall, hit;
    always_comb begin
      rise = primed_q & ~prev_q[i] & pins_i[i];
      fall = primed_q & prev_q[i] & ~pins_i[i];
      if (!xmode_i[i])     hit = rise | fall;
      else if (!kind_i[i]) hit = pol_i[i] ? rise : fall;
      else                 hit = pol_i[i] ? pins_i[i] : ~pins_i[i];
    end
    assign evt_o[i] = hit;
  end

endmodule

// File: rtl/piq_status.sv
module piq_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] st_d, st_q;
  logic         upd;

  always_comb begin
    st_d = (clr_i ? '0 : st_q) | evt_i;
    upd  = clr_i | (|evt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  st_q <= '0;
    else if (upd) st_q <= st_d;
  end

  assign status_o = st_q;

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import piq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [NUM_LINES-1:0] bus_wdata_i,
  output logic [NUM_LINES-1:0] bus_rdata_o,
  output logic                 irq_o
);

  logic [NUM_LINES-1:0] mask_q, xmode_q, kind_q, pol_q, status_q, evt;
  logic wr_mask_set, wr_mask_clr, wr_xm_set, wr_xm_clr;
  logic wr_edge, wr_level, wr_pol_lo, wr_pol_hi, rd_stat;

  always_comb begin
    wr_mask_set = bus_wr_i && (bus_addr_i == A_MASK_SET);
    wr_mask_clr = bus_wr_i && (bus_addr_i == A_MASK_CLR);
    wr_xm_set   = bus_wr_i && (bus_addr_i == A_XM_SET);
    wr_xm_clr   = bus_wr_i && (bus_addr_i == A_XM_CLR);
    wr_edge     = bus_wr_i && (bus_addr_i == A_EDGE);
    wr_level    = bus_wr_i && (bus_addr_i == A_LEVEL);
    wr_pol_lo   = bus_wr_i && (bus_addr_i == A_POL_LO);
    wr_pol_hi   = bus_wr_i && (bus_addr_i == A_POL_HI);
    rd_stat     = bus_rd_i && (bus_addr_i == A_STAT);
  end

  piq_setclr_reg #(.W(NUM_LINES)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_en_i(wr_mask_set), .clr_en_i(wr_mask_clr),
    .data_i(bus_wdata_i), .q_o(mask_q));

  piq_setclr_reg #(.W(NUM_LINES)) u_xmode (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_en_i(wr_xm_set), .clr_en_i(wr_xm_clr),
    .data_i(bus_wdata_i), .q_o(xmode_q));

  piq_setclr_reg #(.W(NUM_LINES)) u_kind (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_en_i(wr_level), .clr_en_i(wr_edge),
    .data_i(bus_wdata_i), .q_o(kind_q));

  piq_setclr_reg #(.W(NUM_LINES)) u_pol (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_en_i(wr_pol_hi), .clr_en_i(wr_pol_lo),
    .data_i(bus_wdata_i), .q_o(pol_q));

  piq_detect #(.W(NUM_LINES)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .xmode_i(xmode_q),
    .kind_i(kind_q), .pol_i(pol_q), .evt_o(evt));

  piq_status #(.W(NUM_LINES)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .clr_i(rd_stat), .status_o(status_q));

  always_comb begin
    case (bus_addr_i)
      A_MASK:  bus_rdata_o = mask_q;
      A_XM:    bus_rdata_o = xmode_q;
      A_KIND:  bus_rdata_o = kind_q;
      A_POL:   bus_rdata_o = pol_q;
      A_STAT:  bus_rdata_o = status_q;
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |(status_q & mask_q);

endmodule

// File: rtl/piq_checker.sv
module piq_checker
  import piq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [W-1:0]      bus_wdata_i,
  input logic              irq_o,
  input logic [W-1:0]      mask,
  input logic [W-1:0]      xmode,
  input logic [W-1:0]      status,
  input logic [W-1:0]      evt
);

  AST_MASK_SET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_MASK_SET) |=> ((mask & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R2

  AST_MASK_CLR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_MASK_CLR) |=> ((mask & $past(bus_wdata_i)) == '0)); // R2

  AST_XMODE_SET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == A_XM_SET) |=> ((xmode & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R3

  AST_READ_LEAVES_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == A_STAT) |=> (status == $past(evt))); // R9

  AST_STATUS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(bus_rd_i && bus_addr_i == A_STAT) && evt == '0) |=> $stable(status)); // R9

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask != '0)); // R10

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status != '0)); // R10

endmodule

bind pin_event_irq piq_checker #(.W(NUM_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .irq_o(irq_o),
  .mask(mask_q), .xmode(xmode_q), .status(status_q), .evt(evt));

// File: tb/tb_pin_event_irq.sv
module tb_pin_event_irq;

  localparam int W = 32;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PIN = 2'd2;

  typedef struct packed {
    logic [1:0]   op;
    logic [3:0]   addr;
    logic [W-1:0] data;
    logic [W-1:0] exp;
    logic         exp_irq;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t TBL [NV] = '{
    '{OP_RD,  4'h2, 32'h0,        32'h0,     1'b0, 4'd1},  // R1 mask
    '{OP_RD,  4'h5, 32'h0,        32'h0,     1'b0, 4'd1},  // R1 xmode
    '{OP_RD,  4'h8, 32'h0,        32'h0,     1'b0, 4'd1},  // R1 kind
    '{OP_RD,  4'hB, 32'h0,        32'h0,     1'b0, 4'd1},  // R1 polarity
    '{OP_RD,  4'hC, 32'h0,        32'h0,     1'b0, 4'd1},  // R1 status
    '{OP_WR,  4'h0, 32'h0000_00FF, 32'h0,    1'b0, 4'd2},  // R2
    '{OP_WR,  4'h1, 32'h0000_000F, 32'h0,    1'b0, 4'd2},  // R2
    '{OP_RD,  4'h2, 32'h0,        32'hF0,    1'b0, 4'd2},  // R2
    '{OP_PIN, 4'h0, 32'h0000_0010, 32'h0,    1'b0, 4'd6},  // R6 rise
    '{OP_RD,  4'hC, 32'h0,        32'h10,    1'b1, 4'd6},  // R6
    '{OP_RD,  4'hC, 32'h0,        32'h0,     1'b0, 4'd9},  // R9 cleared
    '{OP_PIN, 4'h0, 32'h0,        32'h0,     1'b0, 4'd6},  // R6 fall
    '{OP_RD,  4'hC, 32'h0,        32'h10,    1'b1, 4'd6},  // R6
    '{OP_PIN, 4'h0, 32'h0001_0000, 32'h0,    1'b0, 4'd10}, // R10 unmasked line
    '{OP_RD,  4'hC, 32'h0,        32'h1_0000, 1'b0, 4'd10},// R10
    '{OP_WR,  4'h3, 32'h0000_0300, 32'h0,    1'b0, 4'd3},  // R3
    '{OP_WR,  4'h4, 32'h0000_0100, 32'h0,    1'b0, 4'd3},  // R3
    '{OP_RD,  4'h5, 32'h0,        32'h200,   1'b0, 4'd3},  // R3
    '{OP_WR,  4'h3, 32'h0000_0100, 32'h0,    1'b0, 4'd3},  // R3
    '{OP_WR,  4'hA, 32'h0000_0100, 32'h0,    1'b0, 4'd5},  // R5
    '{OP_RD,  4'hB, 32'h0,        32'h100,   1'b0, 4'd5},  // R5
    '{OP_WR,  4'h9, 32'h0000_0100, 32'h0,    1'b0, 4'd5},  // R5
    '{OP_RD,  4'hB, 32'h0,        32'h0,     1'b0, 4'd5},  // R5
    '{OP_WR,  4'hA, 32'h0000_0100, 32'h0,    1'b0, 4'd5},  // R5
    '{OP_PIN, 4'h0, 32'h0001_0300, 32'h0,    1'b0, 4'd7},  // R7 both rise
    '{OP_RD,  4'hC, 32'h0,        32'h100,   1'b0, 4'd7},  // R7
    '{OP_PIN, 4'h0, 32'h0001_0000, 32'h0,    1'b0, 4'd7},  // R7 both fall
    '{OP_RD,  4'hC, 32'h0,        32'h200,   1'b0, 4'd7},  // R7
    '{OP_WR,  4'h7, 32'h0000_3000, 32'h0,    1'b0, 4'd4},  // R4
    '{OP_WR,  4'h6, 32'h0000_2000, 32'h0,    1'b0, 4'd4},  // R4
    '{OP_RD,  4'h8, 32'h0,        32'h1000,  1'b0, 4'd4},  // R4
    '{OP_WR,  4'h3, 32'h0000_1000, 32'h0,    1'b0, 4'd8},  // R8 low level on
    '{OP_RD,  4'hC, 32'h0,        32'h0,     1'b0, 4'd8},  // R8
    '{OP_RD,  4'hC, 32'h0,        32'h1000,  1'b0, 4'd8},  // R8
    '{OP_RD,  4'hC, 32'h0,        32'h1000,  1'b0, 4'd8},  // R8 persists
    '{OP_PIN, 4'h0, 32'h0001_1000, 32'h0,    1'b0, 4'd8},  // R8 level gone
    '{OP_RD,  4'hC, 32'h0,        32'h1000,  1'b0, 4'd8},  // R8
    '{OP_RD,  4'hC, 32'h0,        32'h0,     1'b0, 4'd8}   // R8 stopped
  };

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [W-1:0] pins_i;
  logic         bus_wr_i, bus_rd_i;
  logic [3:0]   bus_addr_i;
  logic [W-1:0] bus_wdata_i;
  logic [W-1:0] bus_rdata_o;
  logic         irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pin_event_irq #(.NUM_LINES(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .bus_wr_i(bus_wr_i),
    .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o));

  task automatic check(input int req, input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [3:0] addr, input logic [W-1:0] data,
                      input logic [W-1:0] exp, input logic exp_irq, input int req);
    @(negedge clk_i);
    bus_wr_i    = (op == OP_WR);
    bus_rd_i    = (op == OP_RD);
    bus_addr_i  = addr;
    bus_wdata_i = (op == OP_WR) ? data : '0;
    if (op == OP_PIN) pins_i = data;
    #1;
    if (op == OP_RD) begin
      check(req, bus_rdata_o, exp, "read data");
      check(req, {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, exp_irq}, "irq");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; pins_i = '0; bus_wr_i = 1'b0; bus_rd_i = 1'b0;
    bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(1, {{(W-1){1'b0}}, irq_o}, '0, "irq after reset"); // R1

    for (int i = 0; i < NV; i++)
      step(TBL[i].op, TBL[i].addr, TBL[i].data, TBL[i].exp, TBL[i].exp_irq, int'(TBL[i].req));

    // R9: pin change lands in the same cycle as the clearing read
    step(OP_RD, 4'hC, 32'h0,       32'h0, 1'b0, 9);
    pins_i = 32'h0001_1001;
    step(OP_RD, 4'hC, 32'h0,       32'h1, 1'b0, 9);

    // R10: masked line raises irq
    step(OP_WR, 4'h0, 32'h1,         32'h0, 1'b0, 10);
    step(OP_PIN, 4'h0, 32'h0001_1000, 32'h0, 1'b0, 10);
    step(OP_RD, 4'hC, 32'h0,         32'h1, 1'b1, 10);
    step(OP_RD, 4'hC, 32'h0,         32'h0, 1'b0, 10);

    // R1: reset with lines already high gives no spurious event
    @(negedge clk_i);
    bus_rd_i = 1'b0; bus_wr_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    step(OP_RD, 4'h2, 32'h0, 32'h0, 1'b0, 1);
    step(OP_RD, 4'hC, 32'h0, 32'h0, 1'b0, 1);
    step(OP_RD, 4'hC, 32'h0, 32'h0, 1'b0, 1);

    @(negedge clk_i);
    bus_rd_i = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule